// File: doc/BRIEF.md
# Bus-Message Interrupt Receiver

This block lets any master on the shared system bus raise one of seven extra interrupt requests on the board without a dedicated wire. A master performs an I/O write to the board's slot address and places a coded byte on the data lines. The receiver checks the address against the board's current role, decodes the byte and latches the matching request. Each latched request drives a level output towards a downstream interrupt controller until that controller, or software acting through it, pulses the request's own clear input.

The slot address has a fixed page in bits [15:8] and a role tag in bits [3:0]. Bits [7:4] are ignored. A board acting as test master answers on tag 0x0, and a board acting as test slave answers on tag 0x8. The data byte carries the line number in its top three bits. Its low five bits are a fixed marker that keeps stray writes, such as the reset codes meant for the interrupt output generator, from raising anything.

Top module: `bmsg_irq_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `req_out` is all zeros, even if a valid write is presented during reset.
- R2: With `role_slave` = 0, a write is accepted only when `bus_addr[15:8]` = 0x09 and `bus_addr[3:0]` = 0x0. The value of `bus_addr[7:4]` has no effect.
- R3: With `role_slave` = 1, a write is accepted only when `bus_addr[15:8]` = 0x09 and `bus_addr[3:0]` = 0x8. A write to tag 0x0 then raises nothing.
- R4: An accepted write whose data has `[15:8]` = 0 and `[4:0]` = 0b01111, with k = `data[7:5]` in the range 0..6, sets `req_out[6-k]`. Bit i of `req_out` is request 9+i, so 0x00CF sets bit 0 (request 9) and 0x000F sets bit 6 (request 15).
- R5: Data with `[4:0]` not equal to 0b01111, with a non-zero upper byte, or equal to 0x00EF (k = 7) changes no output. This includes the generator reset codes 0x0009, 0x000A and 0x000B.
- R6: A raised bit stays high until `req_clr` of the same index is high at a clock edge. That edge clears only that bit.
- R7: If a clear and an accepted set hit the same bit at the same edge, the bit ends up high.
- R8: A repeated write for a bit that is already pending leaves it high and does not change any other bit.
- R9: A set becomes visible on `req_out` at the first rising edge that samples `bus_wr` high. With `bus_wr` low, no bit rises, whatever the address and data are.
- R10: A single write raises at most one bit of `req_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | System-bus I/O address |
| bus_data | input | 16 | System-bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| role_slave | input | 1 | 0: board is test master, 1: board is test slave |
| req_clr | input | 7 | Per-line clear pulse, bit i clears request 9+i |
| req_out | output | 7 | Pending request levels, bit i is request 9+i |

## Verification
The bench targets collisions between a clear and a set on the same line. A design that gave the clear priority would drop that event and leave the line low. It also swaps the role bit between writes to tag 0x0 and tag 0x8, and varies the ignored middle address nibble. A decoder that compared the wrong nibble or ignored the role would raise lines from writes meant for the other board. Near-miss data words are fed in: the generator reset codes, code 0xEF, a corrupted marker and a non-zero upper byte. These expose a decoder that tests only the top bits, or one that maps k = 7 onto a real line. Random traffic with sparse clears checks that pending lines stay sticky and that no write disturbs more than one bit.

// File: rtl/bmsg_irq_pkg.sv
package bmsg_irq_pkg;
   // Result of address qualification for one bus cycle
   typedef enum logic [1:0] {
      SLOT_MISS   = 2'd0,
      SLOT_MASTER = 2'd1,
      SLOT_SLAVE  = 2'd2
   } slot_hit_e;

   // Decoded message fields
   typedef struct packed {
      logic       mark_ok;
      logic       upper_ok;
      logic [2:0] code;
   } msg_fields_t;
endpackage

// File: rtl/bmsg_addr_match.sv
module bmsg_addr_match
   import bmsg_irq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned TAG_W      = 4,
   parameter int unsigned PAGE_LSB   = 8,
   parameter logic [7:0]  PAGE       = 8'h09,
   parameter logic [3:0]  MASTER_TAG = 4'h0,
   parameter logic [3:0]  SLAVE_TAG  = 4'h8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              role_slave,
   output slot_hit_e         hit
);
   localparam int unsigned PAGE_W = ADDR_W - PAGE_LSB;
   localparam int unsigned MID_W  = PAGE_LSB - TAG_W;

   logic page_ok;
   logic tag_m;
   logic tag_s;

   assign page_ok = (addr[ADDR_W-1:PAGE_LSB] == PAGE_W'(PAGE));
   assign tag_m   = (addr[TAG_W-1:0] == TAG_W'(MASTER_TAG));
   assign tag_s   = (addr[TAG_W-1:0] == TAG_W'(SLAVE_TAG));

   // middle nibble is a don't-care by definition
   logic unused_mid;
   assign unused_mid = &{1'b0, addr[TAG_W +: MID_W]};

   always_comb begin
      hit = SLOT_MISS;
      if (page_ok) begin
         if (!role_slave && tag_m)     hit = SLOT_MASTER;
         else if (role_slave && tag_s) hit = SLOT_SLAVE;
      end
   end
endmodule

// File: rtl/bmsg_code_decode.sv
module bmsg_code_decode
   import bmsg_irq_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_REQ    = 7,
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned MARK_W     = 5,
   parameter logic [4:0]  MARK       = 5'b01111,
   parameter bit          UPPER_ZERO = 1'b1
) (
   input  logic [DATA_W-1:0]  data,
   input  logic               enable,
   output logic [NUM_REQ-1:0] set_vec
);
   localparam int unsigned USED_W = MARK_W + CODE_W;

   msg_fields_t f;

   assign f.mark_ok = (data[MARK_W-1:0] == MARK_W'(MARK));
   assign f.code    = 3'(data[MARK_W +: CODE_W]);

   generate
      if (DATA_W > USED_W) begin : g_upper
         if (UPPER_ZERO) begin : g_strict
            assign f.upper_ok = (data[DATA_W-1:USED_W] == '0);
         end else begin : g_loose
            logic unused_upper;
            assign unused_upper = &{1'b0, data[DATA_W-1:USED_W]};
            assign f.upper_ok   = 1'b1;
         end
      end else begin : g_no_upper
         assign f.upper_ok = 1'b1;
      end
   endgenerate

   logic accept;
   assign accept = enable & f.mark_ok & f.upper_ok;

   // line i answers to code value NUM_REQ-1-i; spare codes map to nothing
   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
         assign set_vec[i] = accept && (f.code == 3'(NUM_REQ - 1 - i));
      end
   endgenerate
endmodule

// File: rtl/bmsg_pend_bank.sv
module bmsg_pend_bank #(
   parameter int unsigned NUM_REQ = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] set_vec,
   input  logic [NUM_REQ-1:0] clr_vec,
   output logic [NUM_REQ-1:0] pend
);
   generate
      for (genvar i = 0; i < NUM_REQ; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)          pend[i] <= 1'b0;
            else if (set_vec[i]) pend[i] <= 1'b1;   // set beats clear
            else if (clr_vec[i]) pend[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/bmsg_irq_rx.sv
module bmsg_irq_rx
   import bmsg_irq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NUM_REQ    = 7,
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned MARK_W     = 5,
   parameter logic [4:0]  MARK       = 5'b01111,
   parameter logic [7:0]  PAGE       = 8'h09,
   parameter logic [3:0]  MASTER_TAG = 4'h0,
   parameter logic [3:0]  SLAVE_TAG  = 4'h8,
   parameter bit          UPPER_ZERO = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_data,
   input  logic               bus_wr,
   input  logic               role_slave,
   input  logic [NUM_REQ-1:0] req_clr,
   output logic [NUM_REQ-1:0] req_out
);
   localparam int unsigned TAG_W    = 4;
   localparam int unsigned PAGE_LSB = 8;

   generate
      if (NUM_REQ > (1 << CODE_W) || NUM_REQ == 0) begin : g_bad_req
         $error("NUM_REQ must fit in the code field");
      end
      if (CODE_W != 3) begin : g_bad_code
         $error("CODE_W must be 3");
      end
      if (MARK_W + CODE_W > DATA_W || MARK_W > 5) begin : g_bad_mark
         $error("marker and code must fit in the data word");
      end
      if (ADDR_W <= PAGE_LSB) begin : g_bad_addr
         $error("ADDR_W too small for page field");
      end
   endgenerate

   slot_hit_e          hit;
   logic               wr_ok;
   logic [NUM_REQ-1:0] set_vec;

   bmsg_addr_match #(
      .ADDR_W     (ADDR_W),
      .TAG_W      (TAG_W),
      .PAGE_LSB   (PAGE_LSB),
      .PAGE       (PAGE),
      .MASTER_TAG (MASTER_TAG),
      .SLAVE_TAG  (SLAVE_TAG)
   ) u_match (
      .addr       (bus_addr),
      .role_slave (role_slave),
      .hit        (hit)
   );

   assign wr_ok = bus_wr && (hit != SLOT_MISS);

   bmsg_code_decode #(
      .DATA_W     (DATA_W),
      .NUM_REQ    (NUM_REQ),
      .CODE_W     (CODE_W),
      .MARK_W     (MARK_W),
      .MARK       (MARK),
      .UPPER_ZERO (UPPER_ZERO)
   ) u_decode (
      .data    (bus_data),
      .enable  (wr_ok),
      .set_vec (set_vec)
   );

   bmsg_pend_bank #(
      .NUM_REQ (NUM_REQ)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (req_clr),
      .pend    (req_out)
   );
endmodule

// File: rtl/bmsg_irq_rx_chk.sv
module bmsg_irq_rx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] bus_addr,
   input logic [15:0] bus_data,
   input logic        bus_wr,
   input logic        role_slave,
   input logic [6:0]  req_clr,
   input logic [6:0]  req_out
);
   logic page_hit;
   assign page_hit = (bus_addr[15:8] == 8'h09) &&
                     (bus_addr[3:0] == (role_slave ? 4'h8 : 4'h0));

   // R1: reset clears all lines
   always @(posedge clk) begin
      if (!rst_n) assert_reset_low_R1: assert (req_out == 7'h0 || $isunknown(req_out));
   end

   // R6: a pending line not cleared survives the edge
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(req_out) & ~$past(req_clr)) & ~req_out) == 7'h0));

   // R9: no strobe, no new line
   assert_no_rise_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ((req_out & ~$past(req_out)) == 7'h0));

   // R2 R3: foreign page never raises a line
   assert_foreign_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[15:8] != 8'h09) |=> ((req_out & ~$past(req_out)) == 7'h0));

   // R10: at most one new line per edge
   assert_single_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(req_out & ~$past(req_out)) <= 1));

   // R7: set beats clear for request 15
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page_hit && bus_data == 16'h000F && req_clr[6]) |=> req_out[6]);

   // R5: generator reset codes raise nothing
   assert_reset_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_data[15:2] == 14'h2 && bus_data[1:0] != 2'b00) |=> ((req_out & ~$past(req_out)) == 7'h0));
endmodule

bind bmsg_irq_rx bmsg_irq_rx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_data   (bus_data),
   .bus_wr     (bus_wr),
   .role_slave (role_slave),
   .req_clr    (req_clr),
   .req_out    (req_out)
);

// File: tb/test_bmsg_irq_rx.sv
module test_bmsg_irq_rx;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] bus_addr;
   logic [15:0] bus_data;
   logic        bus_wr;
   logic        role_slave;
   logic [6:0]  req_clr;
   logic [6:0]  req_out;

   int   n_chk  = 0;
   int   n_fail = 0;
   logic [6:0] exp_q = '0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bmsg_irq_rx i_bmsg_irq_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_data   (bus_data),
      .bus_wr     (bus_wr),
      .role_slave (role_slave),
      .req_clr    (req_clr),
      .req_out    (req_out)
   );

   // expected set vector from the requirements (R2 R3 R4 R5)
   function automatic logic [6:0] f_set(input logic [15:0] a, input logic [15:0] d,
                                        input logic r);
      logic [6:0] v;
      int k;
      v = '0;
      if (a[15:8] == 8'h09 && a[3:0] == (r ? 4'h8 : 4'h0) &&
          d[15:8] == 8'h00 && d[4:0] == 5'b01111) begin
         k = int'(d[7:5]);
         if (k != 7) v[6-k] = 1'b1;
      end
      return v;
   endfunction

   task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: req_out=%b expected=%b", tag, act, exp);
      end
   endtask

   // drive at negedge, let one rising edge pass, sample at next negedge
   task automatic step(input logic [15:0] a, input logic [15:0] d, input logic w,
                       input logic [6:0] c, input string tag);
      bus_addr = a;
      bus_data = d;
      bus_wr   = w;
      req_clr  = c;
      exp_q    = (w ? f_set(a, d, role_slave) : 7'h0) | (exp_q & ~c);
      @(posedge clk);
      @(negedge clk);
      check(req_out, exp_q, tag);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: req_out=%b expected=run complete", req_out);
         summary();
      end
   end

   initial begin
      logic [15:0] codes [7];
      int seed;
      codes = '{16'h00CF, 16'h00AF, 16'h008F, 16'h006F, 16'h004F, 16'h002F, 16'h000F};
      seed = $urandom(32'd4711);
      rst_n = 1'b0; role_slave = 1'b0; req_clr = '0;
      bus_addr = 16'h0900; bus_data = 16'h000F; bus_wr = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_out, 7'h0, "R1 valid write held in reset");
      bus_wr = 1'b0;
      rst_n  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(req_out, 7'h0, "R1 first cycle after reset");
      exp_q = '0;

      // R2 master role, middle nibble ignored; R9 one-edge latency
      step(16'h0930, 16'h00CF, 1'b1, 7'h00, "R2 R9 master write sets bit0");
      step(16'h0938, 16'h00AF, 1'b1, 7'h00, "R2 master ignores slave tag");
      // R4 every code, R10 single bit each
      for (int i = 0; i < 7; i++)
         step({8'h09, 4'(i * 2 + 1), 4'h0}, codes[i], 1'b1, 7'h00, "R4 R10 code map");
      step(16'h0900, 16'h0000, 1'b0, 7'h7F, "R6 clear all");
      check(req_out, 7'h00, "R6 all clear direct");
      // R3 slave role
      role_slave = 1'b1;
      step(16'h0950, 16'h000F, 1'b1, 7'h00, "R3 slave ignores master tag");
      check(req_out, 7'h00, "R3 nothing raised on tag 0");
      step(16'h09A8, 16'h000F, 1'b1, 7'h00, "R3 slave tag sets bit6");
      check(req_out, 7'h40, "R4 0x000F is request 15 on bit6");
      // R5 near misses
      step(16'h0908, 16'h0009, 1'b1, 7'h00, "R5 reset code 0009");
      step(16'h0908, 16'h000A, 1'b1, 7'h00, "R5 reset code 000A");
      step(16'h0908, 16'h000B, 1'b1, 7'h00, "R5 reset code 000B");
      step(16'h0908, 16'h00EF, 1'b1, 7'h00, "R5 spare code EF");
      step(16'h0908, 16'h01CF, 1'b1, 7'h00, "R5 upper byte set");
      step(16'h0908, 16'h00CE, 1'b1, 7'h00, "R5 bad marker");
      check(req_out, 7'h40, "R5 only bit6 still pending");
      // R9 strobe low
      step(16'h0908, 16'h00CF, 1'b0, 7'h00, "R9 no strobe no set");
      // R8 repeat
      step(16'h0908, 16'h004F, 1'b1, 7'h00, "R8 first set bit4");
      step(16'h0918, 16'h004F, 1'b1, 7'h00, "R8 repeat keeps bit4");
      check(req_out, 7'h50, "R8 other bits untouched");
      // R7 set wins on collision
      step(16'h0908, 16'h004F, 1'b1, 7'h10, "R7 set beats clear pending");
      step(16'h0908, 16'h00CF, 1'b1, 7'h01, "R7 set beats clear idle");
      check(req_out, 7'h51, "R7 collision result");
      // R6 selective clear
      step(16'h0900, 16'h0000, 1'b0, 7'h40, "R6 clear bit6 only");
      check(req_out, 7'h11, "R6 others remain");

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a;
         logic [15:0] d;
         logic [6:0]  c;
         if ($urandom_range(0, 15) == 0) role_slave = ~role_slave;
         case ($urandom_range(0, 3))
            0: a = 16'($urandom);
            1: a = {8'h09, 4'($urandom), 4'h0};
            2: a = {8'h09, 4'($urandom), 4'h8};
            default: a = {8'h09, 4'($urandom), 4'($urandom)};
         endcase
         case ($urandom_range(0, 3))
            0: d = 16'($urandom);
            1: d = {8'h00, 8'($urandom)};
            default: d = {8'h00, 3'($urandom), 5'b01111};
         endcase
         c = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00;
         step(a, d, 1'($urandom), c, "R4 R6 R7 R10 random");
      end

      done = 1'b1;
      summary();
   end
endmodule